// File: doc/BRIEF.md
# Strided Vector Load Unit

This block carries out one vector load at a time. A command gives a word base address, a word stride, an element count and a destination vector register. The unit then walks the addresses base, base+stride, base+2*stride and so on. It sends one read per cycle at most to a memory that is interleaved over 16 banks of 64-bit words. It writes each returned word into the next element of the chosen register, starting at element 0.

Each bank needs four processor cycles to recover after an access. The unit keeps a small down-counter per bank and holds back the next address while the counter for its bank is still running. A unit stride therefore streams at one element per clock. A stride that lands on the same bank every time, such as any multiple of 16, is limited to one element every four clocks.

The memory answers in request order with any latency. Each answer is written straight into the register file. A single-cycle completion pulse follows the last write.

Top module: `vload_unit`

## Requirements
- R1: Request k of a command (counting from 0) carries the word address base + k*stride modulo 2^24, and its bank number is the low four bits of that address. At most one request is issued per cycle.
- R2: Once a bank has been requested in cycle t, no request goes to that bank before cycle t+4.
- R3: A stride of 1, of 2 or of 3 issues its N requests over N consecutive cycles. A stride that is a multiple of 16 spaces requests exactly four cycles apart. A stride of 8 issues pairs: element i goes out 4*(i/2) + (i mod 2) cycles after element 0.
- R4: The k-th response of a command is written with write enable high, register select equal to the command's destination register (0..7), element index k, and the response word unchanged.
- R5: `done` is high for exactly one cycle, in the cycle right after the write of the last element.
- R6: An element count of 0 issues no memory request and raises `done` in the cycle after the start is taken.
- R7: An element count above 64 is treated as 64: exactly 64 requests and 64 writes, with indices 0..63.
- R8: During reset and right after it, there is no request, no register write and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a load; taken only while no load is running |
| start_base | input | 24 | Word address of element 0 |
| start_stride | input | 24 | Word stride between elements, modulo 2^24 |
| start_len | input | 8 | Element count, clamped to 64 |
| start_vd | input | 3 | Destination vector register |
| mem_req_valid | output | 1 | A read request is issued this cycle |
| mem_req_bank | output | 4 | Bank number of the request |
| mem_req_addr | output | 24 | Word address of the request |
| mem_rsp_valid | input | 1 | A read word returns this cycle |
| mem_rsp_data | input | 64 | Returned word |
| vr_we | output | 1 | Register file write enable |
| vr_sel | output | 3 | Register being written |
| vr_idx | output | 6 | Element being written |
| vr_data | output | 64 | Element data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The checks assume that the memory returns exactly one word for each request, in request order. They also assume that no word arrives when nothing is outstanding, and that `start` is raised only after the previous load has pulsed `done`. The bench memory answers through a fixed three-stage pipeline that follows the request stream. Each directed scenario waits for the completion pulse before it issues the next command, so every load runs alone and every response belongs to the load in progress.

// File: rtl/vload_pkg.sv
package vload_pkg;
   typedef enum logic {
      VL_IDLE = 1'b0,
      VL_RUN  = 1'b1
   } vl_state_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/vload_bank_timers.sv
module vload_bank_timers #(
   parameter int NBANKS   = 16,
   parameter int BUSY_CYC = 4,
   localparam int BANK_W  = $clog2(NBANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [BANK_W-1:0] issue_bank,
   output logic [NBANKS-1:0] bank_busy
);
   if (BUSY_CYC <= 1) begin : g_no_timer
      assign bank_busy = '0;
   end else begin : g_timer
      localparam int CW = $clog2(BUSY_CYC);
      for (genvar b = 0; b < NBANKS; b++) begin : g_bank
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (issue && (issue_bank == BANK_W'(b)))
               cnt_q <= CW'(BUSY_CYC - 1);
            else if (cnt_q != '0)
               cnt_q <= cnt_q - 1'b1;
         end
         assign bank_busy[b] = (cnt_q != '0);
      end
   end
endmodule

// File: rtl/vload_addr_gen.sv
module vload_addr_gen #(
   parameter int ADDR_W  = 24,
   parameter int NBANKS  = 16,
   parameter int LEN_W   = 7,
   localparam int BANK_W = $clog2(NBANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] stride,
   input  logic [LEN_W-1:0]  len,
   input  logic [NBANKS-1:0] bank_busy,
   output logic              req_valid,
   output logic [BANK_W-1:0] req_bank,
   output logic [ADDR_W-1:0] req_addr
);
   logic [ADDR_W-1:0] cur_q, stride_q;
   logic [LEN_W-1:0]  left_q;

   assign req_addr  = cur_q;
   assign req_bank  = cur_q[BANK_W-1:0];
   assign req_valid = (left_q != '0) && !bank_busy[req_bank];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q    <= '0;
         stride_q <= '0;
         left_q   <= '0;
      end else if (load) begin
         cur_q    <= base;
         stride_q <= stride;
         left_q   <= len;
      end else if (req_valid) begin
         cur_q    <= cur_q + stride_q;
         left_q   <= left_q - 1'b1;
      end
   end
endmodule

// File: rtl/vload_writeback.sv
module vload_writeback #(
   parameter int WORD_W  = 64,
   parameter int MAXVL   = 64,
   parameter int NVREG   = 8,
   parameter int LEN_W   = 7,
   localparam int IDX_W  = $clog2(MAXVL),
   localparam int SEL_W  = $clog2(NVREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              load_empty,
   input  logic [LEN_W-1:0]  len,
   input  logic [SEL_W-1:0]  vd,
   input  logic              rsp_valid,
   input  logic [WORD_W-1:0] rsp_data,
   output logic              vr_we,
   output logic [SEL_W-1:0]  vr_sel,
   output logic [IDX_W-1:0]  vr_idx,
   output logic [WORD_W-1:0] vr_data,
   output logic              done
);
   logic [LEN_W-1:0] cnt_q, len_q;
   logic [SEL_W-1:0] vd_q;
   logic             run_q, done_q;
   logic             last_wr;

   assign vr_we   = run_q && rsp_valid;
   assign vr_sel  = vd_q;
   assign vr_idx  = cnt_q[IDX_W-1:0];
   assign vr_data = rsp_data;
   assign done    = done_q;
   assign last_wr = vr_we && (cnt_q == len_q - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         len_q  <= '0;
         vd_q   <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= last_wr || load_empty;
         if (load) begin
            cnt_q <= '0;
            len_q <= len;
            vd_q  <= vd;
            run_q <= 1'b1;
         end else if (vr_we) begin
            cnt_q <= cnt_q + 1'b1;
            if (last_wr) run_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/vload_unit.sv
module vload_unit #(
   parameter int ADDR_W   = 24,
   parameter int WORD_W   = 64,
   parameter int NBANKS   = 16,
   parameter int BUSY_CYC = 4,
   parameter int MAXVL    = 64,
   parameter int NVREG    = 8,
   parameter int LEN_IN_W = 8,
   localparam int BANK_W  = $clog2(NBANKS),
   localparam int LEN_W   = $clog2(MAXVL + 1),
   localparam int IDX_W   = $clog2(MAXVL),
   localparam int SEL_W   = $clog2(NVREG)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [ADDR_W-1:0]   start_base,
   input  logic [ADDR_W-1:0]   start_stride,
   input  logic [LEN_IN_W-1:0] start_len,
   input  logic [SEL_W-1:0]    start_vd,
   output logic                mem_req_valid,
   output logic [BANK_W-1:0]   mem_req_bank,
   output logic [ADDR_W-1:0]   mem_req_addr,
   input  logic                mem_rsp_valid,
   input  logic [WORD_W-1:0]   mem_rsp_data,
   output logic                vr_we,
   output logic [SEL_W-1:0]    vr_sel,
   output logic [IDX_W-1:0]    vr_idx,
   output logic [WORD_W-1:0]   vr_data,
   output logic                done
);
   import vload_pkg::*;

   if (!is_pow2(NBANKS)) begin : g_bad_banks
      $error("NBANKS must be a power of two");
   end
   if (!is_pow2(MAXVL)) begin : g_bad_vl
      $error("MAXVL must be a power of two");
   end
   if (LEN_IN_W < LEN_W) begin : g_bad_len
      $error("LEN_IN_W too narrow for MAXVL");
   end
   if (BANK_W > ADDR_W) begin : g_bad_addr
      $error("ADDR_W narrower than bank index");
   end

   vl_state_e        state_q;
   logic             accept, load_run, load_empty;
   logic [LEN_W-1:0] len_c;
   logic [NBANKS-1:0] bank_busy;

   assign accept     = start && (state_q == VL_IDLE);
   assign len_c      = (start_len > LEN_IN_W'(MAXVL)) ? LEN_W'(MAXVL)
                                                       : start_len[LEN_W-1:0];
   assign load_run   = accept && (len_c != '0);
   assign load_empty = accept && (len_c == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         state_q <= VL_IDLE;
      else if (load_run)
         state_q <= VL_RUN;
      else if (done)
         state_q <= VL_IDLE;
   end

   vload_bank_timers #(.NBANKS(NBANKS), .BUSY_CYC(BUSY_CYC)) u_timers (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue      (mem_req_valid),
      .issue_bank (mem_req_bank),
      .bank_busy  (bank_busy)
   );

   vload_addr_gen #(.ADDR_W(ADDR_W), .NBANKS(NBANKS), .LEN_W(LEN_W)) u_agen (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_run),
      .base      (start_base),
      .stride    (start_stride),
      .len       (len_c),
      .bank_busy (bank_busy),
      .req_valid (mem_req_valid),
      .req_bank  (mem_req_bank),
      .req_addr  (mem_req_addr)
   );

   vload_writeback #(.WORD_W(WORD_W), .MAXVL(MAXVL), .NVREG(NVREG), .LEN_W(LEN_W)) u_wb (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load_run),
      .load_empty (load_empty),
      .len        (len_c),
      .vd         (start_vd),
      .rsp_valid  (mem_rsp_valid),
      .rsp_data   (mem_rsp_data),
      .vr_we      (vr_we),
      .vr_sel     (vr_sel),
      .vr_idx     (vr_idx),
      .vr_data    (vr_data),
      .done       (done)
   );
endmodule

// File: rtl/vload_unit_chk.sv
module vload_unit_chk #(
   parameter int ADDR_W   = 24,
   parameter int NBANKS   = 16,
   parameter int BUSY_CYC = 4,
   parameter int LEN_IN_W = 8,
   parameter int IDX_W    = 6,
   localparam int BANK_W  = $clog2(NBANKS),
   localparam int GAP_W   = $clog2(BUSY_CYC + 1)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                busy_run,
   input logic [ADDR_W-1:0]   start_stride,
   input logic [LEN_IN_W-1:0] start_len,
   input logic                mem_req_valid,
   input logic [BANK_W-1:0]   mem_req_bank,
   input logic [ADDR_W-1:0]   mem_req_addr,
   input logic                vr_we,
   input logic [IDX_W-1:0]    vr_idx,
   input logic                done
);
   logic              taken;
   logic [ADDR_W-1:0] stride_l, prev_addr;
   logic              have_prev, have_wr;
   logic [IDX_W-1:0]  last_idx;
   logic [GAP_W-1:0]  since [NBANKS];

   assign taken = start && !busy_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stride_l  <= '0;
         prev_addr <= '0;
         have_prev <= 1'b0;
         have_wr   <= 1'b0;
         last_idx  <= '0;
      end else begin
         if (taken) begin
            stride_l  <= start_stride;
            have_prev <= 1'b0;
         end else if (mem_req_valid) begin
            prev_addr <= mem_req_addr;
            have_prev <= 1'b1;
         end
         if (done) have_wr <= 1'b0;
         else if (vr_we) begin
            have_wr  <= 1'b1;
            last_idx <= vr_idx;
         end
      end
   end

   for (genvar b = 0; b < NBANKS; b++) begin : g_gap
      always_ff @(posedge clk) begin
         if (!rst_n)
            since[b] <= GAP_W'(BUSY_CYC);
         else if (mem_req_valid && mem_req_bank == BANK_W'(b))
            since[b] <= GAP_W'(1);
         else if (since[b] != GAP_W'(BUSY_CYC))
            since[b] <= since[b] + 1'b1;
      end
   end

   a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && have_prev) |-> (mem_req_addr == prev_addr + stride_l));

   a_r2_bank_gap: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (since[mem_req_bank] == GAP_W'(BUSY_CYC)));

   a_r4_idx_order: assert property (@(posedge clk) disable iff (!rst_n)
      vr_we |-> (have_wr ? (vr_idx == last_idx + 1'b1) : (vr_idx == '0)));

   a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r6_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && start_len == '0) |=> (done && !mem_req_valid));
endmodule

bind vload_unit vload_unit_chk #(
   .ADDR_W(ADDR_W), .NBANKS(NBANKS), .BUSY_CYC(BUSY_CYC),
   .LEN_IN_W(LEN_IN_W), .IDX_W(IDX_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start         (start),
   .busy_run      (state_q == vload_pkg::VL_RUN),
   .start_stride  (start_stride),
   .start_len     (start_len),
   .mem_req_valid (mem_req_valid),
   .mem_req_bank  (mem_req_bank),
   .mem_req_addr  (mem_req_addr),
   .vr_we         (vr_we),
   .vr_idx        (vr_idx),
   .done          (done)
);

// File: tb/vload_unit_test.sv
module vload_unit_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [23:0] start_base = '0, start_stride = '0;
   logic [7:0]  start_len = '0;
   logic [2:0]  start_vd = '0;
   logic        mem_req_valid;
   logic [3:0]  mem_req_bank;
   logic [23:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [63:0] mem_rsp_data;
   logic        vr_we;
   logic [2:0]  vr_sel;
   logic [5:0]  vr_idx;
   logic [63:0] vr_data;
   logic        done;

   int total = 0, bad = 0;
   int cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   vload_unit uut (.*);

   function automatic logic [63:0] mem_word(input logic [23:0] a);
      return {8'h5A, a, 8'hC3, ~a};
   endfunction

   // in-order memory with a fixed three-cycle return
   logic        p_v [3];
   logic [23:0] p_a [3];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 3; i++) begin p_v[i] <= 1'b0; p_a[i] <= '0; end
      end else begin
         p_v[0] <= mem_req_valid; p_a[0] <= mem_req_addr;
         p_v[1] <= p_v[0];        p_a[1] <= p_a[0];
         p_v[2] <= p_v[1];        p_a[2] <= p_a[1];
      end
   end
   assign mem_rsp_valid = p_v[2];
   assign mem_rsp_data  = mem_word(p_a[2]);

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor state
   logic [23:0] e_base, e_stride;
   logic [2:0]  e_vd;
   int e_len, req_cnt, wr_cnt, done_cnt, first_cyc, last_cyc;
   int e_sched [64];
   bit use_sched, pend_done;
   int bank_last [16];

   always @(negedge clk) begin
      if (rst_n) begin
         if (pend_done) check(done === 1'b1, "R5", "done after last write", done, 1);
         pend_done = 1'b0;
         if (done) done_cnt++;
         if (mem_req_valid) begin
            logic [23:0] ea;
            ea = e_base + 24'(req_cnt) * e_stride;
            check(mem_req_addr === ea, "R1", "request address", mem_req_addr, ea);
            check(mem_req_bank === ea[3:0], "R1", "request bank", mem_req_bank, ea[3:0]);
            check(cyc - bank_last[mem_req_bank] >= 4, "R2", "bank gap",
                  cyc - bank_last[mem_req_bank], 4);
            bank_last[mem_req_bank] = cyc;
            if (req_cnt == 0) first_cyc = cyc;
            if (use_sched && req_cnt < 64)
               check(cyc - first_cyc == e_sched[req_cnt], "R3", "issue cycle",
                     cyc - first_cyc, e_sched[req_cnt]);
            last_cyc = cyc;
            req_cnt++;
         end
         if (vr_we) begin
            logic [63:0] ed;
            ed = mem_word(e_base + 24'(wr_cnt) * e_stride);
            check(vr_idx == 6'(wr_cnt), "R4", "element index", vr_idx, wr_cnt);
            check(vr_sel === e_vd, "R4", "register select", vr_sel, e_vd);
            check(vr_data === ed, "R4", "element data", vr_data, ed);
            wr_cnt++;
            if (wr_cnt == e_len) pend_done = 1'b1;
         end
      end
   end

   task automatic run_load(input logic [23:0] base, input logic [23:0] stride,
                           input logic [7:0] len, input logic [2:0] vd,
                           input bit sched, input string tag);
      e_base = base; e_stride = stride; e_vd = vd;
      e_len = (len > 64) ? 64 : int'(len);
      req_cnt = 0; wr_cnt = 0; done_cnt = 0; use_sched = sched;
      for (int b = 0; b < 16; b++) bank_last[b] = -100;
      start_base = base; start_stride = stride; start_len = len; start_vd = vd;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 2000 && done_cnt == 0; i++) @(negedge clk);
      repeat (4) @(negedge clk);
      check(done_cnt == 1, tag, "done pulse count", done_cnt, 1);
      check(req_cnt == e_len, tag, "request count", req_cnt, e_len);
      check(wr_cnt == e_len, tag, "write count", wr_cnt, e_len);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(!mem_req_valid && !vr_we && !done, "R8", "outputs in reset", 0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!mem_req_valid && !vr_we && !done, "R8", "outputs after reset", 0, 0);
   endtask

   task automatic t_unit_stride();
      for (int i = 0; i < 64; i++) e_sched[i] = i;
      run_load(24'h000100, 24'd1, 8'd16, 3'd2, 1'b1, "R3");   // R3 stride 1
      run_load(24'h000207, 24'd3, 8'd20, 3'd5, 1'b1, "R3");   // R3 stride 3
      run_load(24'h000010, 24'hFFFFFF, 8'd10, 3'd1, 1'b1, "R1"); // R1 wrap
   endtask

   task automatic t_same_bank();
      for (int i = 0; i < 64; i++) e_sched[i] = 4 * i;
      run_load(24'h000040, 24'd16, 8'd8, 3'd3, 1'b1, "R3");   // R3 stride 16
      run_load(24'h000005, 24'd32, 8'd6, 3'd7, 1'b1, "R3");   // R3 stride 32
   endtask

   task automatic t_pair_stride();
      for (int i = 0; i < 64; i++) e_sched[i] = 4 * (i / 2) + (i % 2);
      run_load(24'h000000, 24'd8, 8'd8, 3'd4, 1'b1, "R3");    // R3 stride 8
   endtask

   task automatic t_empty();
      int seen;
      e_len = 0; req_cnt = 0; wr_cnt = 0; done_cnt = 0; use_sched = 1'b0;
      start_len = 8'd0; start_base = 24'h123; start_stride = 24'd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      seen = done;
      check(seen == 1, "R6", "done one cycle after start", seen, 1);
      repeat (5) @(negedge clk);
      check(req_cnt == 0 && wr_cnt == 0, "R6", "no access", req_cnt, 0);
      check(done_cnt == 1, "R6", "single done", done_cnt, 1);
   endtask

   task automatic t_clamp();
      for (int i = 0; i < 64; i++) e_sched[i] = i;
      run_load(24'h000800, 24'd1, 8'd200, 3'd6, 1'b1, "R7");  // R7 clamp
      run_load(24'h000900, 24'd2, 8'd64, 3'd0, 1'b1, "R7");   // R7 exact max
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      bad++; total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      e_base = '0; e_stride = '0; e_vd = '0; e_len = 0;
      req_cnt = 0; wr_cnt = 0; done_cnt = 0; first_cyc = 0; last_cyc = 0;
      use_sched = 1'b0; pend_done = 1'b0;
      for (int b = 0; b < 16; b++) bank_last[b] = -100;
      for (int i = 0; i < 64; i++) e_sched[i] = 0;
      @(negedge clk);
      t_reset();
      t_unit_stride();
      t_same_bank();
      t_pair_stride();
      t_empty();
      t_clamp();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule